// File: doc/BRIEF.md
# Per-Element Transverse Energy Summation Engine

This block receives one calorimeter jet element at a time, each with an electromagnetic and a hadronic energy value and a position index. Each of the two values is first compared against its own programmable noise cut; values that do not clear the cut are dropped to zero. The surviving values are added into a 10-bit transverse energy for the element. A position-indexed weight table turns that energy into x and y components. Total, x and y energy are then accumulated over a frame whose length in elements is set at run time.

The block runs on the double-rate clock, so one crossing spans two clock cycles. Each element's 10-bit energy is also handed on to a downstream jet finder as two 5-bit words on consecutive cycles. The low half comes first and is marked by a phase strobe, and the high half follows. The frame sums saturate rather than wrap, and each sum has an overflow flag that describes the frame just reported.

Top module: `et_sum_engine`

## Requirements
- R1: After reset, sum_valid, jf_valid and jf_first are 0, jf_data is 0, all three sums are 0, all three overflow flags are 0, and every weight-table entry is 0.
- R2: An electromagnetic value less than or equal to thr_em counts as zero. A hadronic value less than or equal to thr_had counts as zero. Each comparison is made independently of the other.
- R3: The element energy is the sum of the two thresholded values, 10 bits unsigned. The element is accepted at a clock edge. At the next edge, jf_data carries energy bits [4:0] with jf_first=1 and jf_valid=1. At the edge after that, jf_data carries bits [9:5] with jf_first=0 and jf_valid=1. jf_valid is 0 in the cycles that follow.
- R4: The x contribution of an element is floor(E*C/256) and the y contribution is floor(E*S/256). E is the thresholded element energy. C and S are the 10-bit two's-complement weights stored at table entry elem_idx, where 256 means 1.0.
- R5: When lut_we is high at a clock edge, lut_cos and lut_sin are written to entry lut_addr. They are used by elements accepted at later edges.
- R6: When the last element of a frame is accepted at an edge, sum_valid is high for exactly one cycle from the next edge. sum_et, sum_ex and sum_ey then hold the frame totals, and they keep those values until the next frame completes. Accumulation restarts from zero for the next frame.
- R7: A frame has frame_len elements. A frame_len of 0 behaves as 1.
- R8: sum_et is unsigned, 16 bits, and saturates at 65535. sum_ex and sum_ey are signed 16-bit values that saturate at 32767 and -32768. ovf_et, ovf_ex and ovf_ey show whether the matching sum saturated at any point during the reported frame.
- R9: An elem_valid in the cycle right after an accepted element is ignored. That element adds nothing to the sums and sends nothing to the jet finder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| elem_valid | input | 1 | Element present this cycle |
| elem_em | input | 9 | Electromagnetic energy |
| elem_had | input | 9 | Hadronic energy |
| elem_idx | input | 4 | Element position index |
| thr_em | input | 9 | Electromagnetic noise cut |
| thr_had | input | 9 | Hadronic noise cut |
| frame_len | input | 8 | Elements per frame (0 acts as 1) |
| lut_we | input | 1 | Weight table write enable |
| lut_addr | input | 4 | Weight table write address |
| lut_cos | input | 10 | Signed x weight, 8 fractional bits |
| lut_sin | input | 10 | Signed y weight, 8 fractional bits |
| jf_data | output | 5 | Energy half-word to jet finder |
| jf_valid | output | 1 | jf_data carries a half-word |
| jf_first | output | 1 | High while the low half is sent |
| sum_valid | output | 1 | Frame sums updated |
| sum_et | output | 16 | Frame total energy |
| sum_ex | output | 16 | Frame x energy, signed |
| sum_ey | output | 16 | Frame y energy, signed |
| ovf_et | output | 1 | Total saturated in frame |
| ovf_ex | output | 1 | X sum saturated in frame |
| ovf_ey | output | 1 | Y sum saturated in frame |

## Verification
The hardest condition to reach is saturation in all three sums within one frame, and seeing the flags clear again in the next frame. The stimulus first writes unit weights of opposite sign into one table entry. It then sends a 70-element frame of full-scale elements at that index, which drives the total past 65535 and the x and y sums past both signed limits. A short frame follows at once. The ignored back-to-back element is reached by holding elem_valid for two cycles with different data in the second. The test then checks that neither the jet-finder words nor the sums show the second element.

// File: rtl/et_sum_pkg.sv
package et_sum_pkg;
  typedef enum logic {
    JF_IDLE = 1'b0,
    JF_HIGH = 1'b1
  } jf_state_e;
endpackage

// File: rtl/et_threshold_sum.sv
module et_threshold_sum #(
  parameter int E_W   = 9,
  parameter int IDX_W = 4,
  localparam int ET_W = E_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [E_W-1:0]   em,
  input  logic [E_W-1:0]   had,
  input  logic [IDX_W-1:0] idx,
  input  logic [E_W-1:0]   thr_em,
  input  logic [E_W-1:0]   thr_had,
  output logic             v_q,
  output logic [ET_W-1:0]  et_q,
  output logic [IDX_W-1:0] idx_q
);
  function automatic logic [E_W-1:0] cut(input logic [E_W-1:0] v, input logic [E_W-1:0] t);
    return (v > t) ? v : '0;
  endfunction

  logic [E_W-1:0] em_cut, had_cut;
  assign em_cut  = cut(em, thr_em);
  assign had_cut = cut(had, thr_had);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      et_q  <= '0;
      idx_q <= '0;
    end else begin
      v_q <= accept;
      if (accept) begin
        et_q  <= {1'b0, em_cut} + {1'b0, had_cut};
        idx_q <= idx;
      end
    end
  end

  // R2: both values at or below their cuts give zero energy
  p_thr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept) && ($past(em) <= $past(thr_em)) && ($past(had) <= $past(thr_had)))
      |-> (et_q == '0));
endmodule

// File: rtl/et_proj_lut.sv
module et_proj_lut #(
  parameter int NPOS  = 16,
  parameter int ET_W  = 10,
  parameter int WGT_W = 10,
  parameter int FRAC  = 8,
  localparam int IDX_W  = $clog2(NPOS),
  localparam int PROD_W = ET_W + 1 + WGT_W,
  localparam int PROJ_W = PROD_W - FRAC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         waddr,
  input  logic signed [WGT_W-1:0]  wcos,
  input  logic signed [WGT_W-1:0]  wsin,
  input  logic [IDX_W-1:0]         ridx,
  input  logic [ET_W-1:0]          et,
  output logic signed [PROJ_W-1:0] px,
  output logic signed [PROJ_W-1:0] py
);
  logic signed [WGT_W-1:0] cos_tab [NPOS];
  logic signed [WGT_W-1:0] sin_tab [NPOS];

  function automatic logic signed [PROJ_W-1:0] project(input logic [ET_W-1:0] e,
                                                       input logic signed [WGT_W-1:0] w);
    logic signed [PROD_W-1:0] ea, wa, p;
    ea = $signed({{WGT_W{1'b0}}, e});
    wa = $signed({{(ET_W+1){w[WGT_W-1]}}, w});
    p  = ea * wa;
    return PROJ_W'(p >>> FRAC);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPOS; i++) begin
        cos_tab[i] <= '0;
        sin_tab[i] <= '0;
      end
    end else if (we) begin
      cos_tab[waddr] <= wcos;
      sin_tab[waddr] <= wsin;
    end
  end

  assign px = project(et, cos_tab[ridx]);
  assign py = project(et, sin_tab[ridx]);

  // R5: a write lands in the addressed entry
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we) |-> (cos_tab[$past(waddr)] == $past(wcos)) && (sin_tab[$past(waddr)] == $past(wsin)));
endmodule

// File: rtl/et_accum.sv
module et_accum #(
  parameter int IN_W   = 10,
  parameter int SUM_W  = 16,
  parameter bit SIGNED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic             last,
  input  logic [IN_W-1:0]  in_val,
  output logic [SUM_W-1:0] sum_q,
  output logic             ovf_q
);
  logic [SUM_W-1:0] acc;
  logic             acc_ovf;
  logic [SUM_W:0]   ext_a, ext_b, wide;
  logic [SUM_W-1:0] nxt;
  logic             ovf_now;
  logic             in_msb;

  assign in_msb = SIGNED ? in_val[IN_W-1] : 1'b0;
  assign ext_a  = SIGNED ? {acc[SUM_W-1], acc} : {1'b0, acc};
  assign ext_b  = {{(SUM_W+1-IN_W){in_msb}}, in_val};
  assign wide   = ext_a + ext_b;

  always_comb begin
    if (SIGNED) begin
      ovf_now = wide[SUM_W] ^ wide[SUM_W-1];
      if (!ovf_now)       nxt = wide[SUM_W-1:0];
      else if (wide[SUM_W]) nxt = {1'b1, {(SUM_W-1){1'b0}}};
      else                nxt = {1'b0, {(SUM_W-1){1'b1}}};
    end else begin
      ovf_now = wide[SUM_W];
      nxt     = ovf_now ? '1 : wide[SUM_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      acc_ovf <= 1'b0;
      sum_q   <= '0;
      ovf_q   <= 1'b0;
    end else if (add_en) begin
      if (last) begin
        sum_q   <= nxt;
        ovf_q   <= acc_ovf | ovf_now;
        acc     <= '0;
        acc_ovf <= 1'b0;
      end else begin
        acc     <= nxt;
        acc_ovf <= acc_ovf | ovf_now;
      end
    end
  end

  // R8: a saturation during the closing add is reported with the frame
  p_ovf_report_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && last && ovf_now) |=> ovf_q);

  generate
    if (!SIGNED) begin : g_unsigned
      // R8: the unsigned running total never decreases inside a frame
      p_total_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !last) |=> (acc >= $past(acc)));
    end
  endgenerate
endmodule

// File: rtl/et_jf_serializer.sv
module et_jf_serializer
  import et_sum_pkg::*;
#(
  parameter int ET_W = 10,
  localparam int JF_W = (ET_W + 1) / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ET_W-1:0] et,
  output logic [JF_W-1:0] jf_data,
  output logic            jf_valid,
  output logic            jf_first
);
  jf_state_e          st;
  logic [JF_W-1:0]    hi_q;
  logic [2*JF_W-1:0]  et_pad;

  assign et_pad = (2*JF_W)'(et);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= JF_IDLE;
      hi_q     <= '0;
      jf_data  <= '0;
      jf_valid <= 1'b0;
      jf_first <= 1'b0;
    end else if (load) begin
      jf_data  <= et_pad[JF_W-1:0];
      hi_q     <= et_pad[2*JF_W-1:JF_W];
      jf_valid <= 1'b1;
      jf_first <= 1'b1;
      st       <= JF_HIGH;
    end else if (st == JF_HIGH) begin
      jf_data  <= hi_q;
      jf_valid <= 1'b1;
      jf_first <= 1'b0;
      st       <= JF_IDLE;
    end else begin
      jf_data  <= '0;
      jf_valid <= 1'b0;
      jf_first <= 1'b0;
    end
  end

  // R3: the high half always follows the low half
  p_hi_follows_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (jf_valid && jf_first) |=> (jf_valid && !jf_first));
  // R9: no new element arrives while the high half is pending
  p_no_load_in_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == JF_HIGH) |-> !load);
endmodule

// File: rtl/et_sum_engine.sv
module et_sum_engine #(
  parameter int E_W   = 9,
  parameter int NPOS  = 16,
  parameter int WGT_W = 10,
  parameter int FRAC  = 8,
  parameter int SUM_W = 16,
  parameter int CNT_W = 8,
  localparam int IDX_W  = $clog2(NPOS),
  localparam int ET_W   = E_W + 1,
  localparam int JF_W   = (ET_W + 1) / 2,
  localparam int PROJ_W = ET_W + 1 + WGT_W - FRAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             elem_valid,
  input  logic [E_W-1:0]   elem_em,
  input  logic [E_W-1:0]   elem_had,
  input  logic [IDX_W-1:0] elem_idx,
  input  logic [E_W-1:0]   thr_em,
  input  logic [E_W-1:0]   thr_had,
  input  logic [CNT_W-1:0] frame_len,
  input  logic             lut_we,
  input  logic [IDX_W-1:0] lut_addr,
  input  logic [WGT_W-1:0] lut_cos,
  input  logic [WGT_W-1:0] lut_sin,
  output logic [JF_W-1:0]  jf_data,
  output logic             jf_valid,
  output logic             jf_first,
  output logic             sum_valid,
  output logic [SUM_W-1:0] sum_et,
  output logic [SUM_W-1:0] sum_ex,
  output logic [SUM_W-1:0] sum_ey,
  output logic             ovf_et,
  output logic             ovf_ex,
  output logic             ovf_ey
);
  logic                     accept;
  logic                     v1;
  logic [ET_W-1:0]          et1;
  logic [IDX_W-1:0]         idx1;
  logic signed [PROJ_W-1:0] px, py;
  logic [CNT_W-1:0]         elem_cnt;
  logic                     frame_last;

  assign accept     = elem_valid & ~v1;
  assign frame_last = ((CNT_W+1)'(elem_cnt) + (CNT_W+1)'(1)) >= (CNT_W+1)'(frame_len);

  et_threshold_sum #(.E_W(E_W), .IDX_W(IDX_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .em(elem_em), .had(elem_had), .idx(elem_idx),
    .thr_em(thr_em), .thr_had(thr_had),
    .v_q(v1), .et_q(et1), .idx_q(idx1)
  );

  et_proj_lut #(.NPOS(NPOS), .ET_W(ET_W), .WGT_W(WGT_W), .FRAC(FRAC)) u_lut (
    .clk(clk), .rst_n(rst_n), .we(lut_we), .waddr(lut_addr),
    .wcos(lut_cos), .wsin(lut_sin), .ridx(idx1), .et(et1),
    .px(px), .py(py)
  );

  et_jf_serializer #(.ET_W(ET_W)) u_jf (
    .clk(clk), .rst_n(rst_n), .load(v1), .et(et1),
    .jf_data(jf_data), .jf_valid(jf_valid), .jf_first(jf_first)
  );

  et_accum #(.IN_W(ET_W), .SUM_W(SUM_W), .SIGNED(1'b0)) u_acc_et (
    .clk(clk), .rst_n(rst_n), .add_en(v1), .last(frame_last),
    .in_val(et1), .sum_q(sum_et), .ovf_q(ovf_et)
  );

  et_accum #(.IN_W(PROJ_W), .SUM_W(SUM_W), .SIGNED(1'b1)) u_acc_ex (
    .clk(clk), .rst_n(rst_n), .add_en(v1), .last(frame_last),
    .in_val(px), .sum_q(sum_ex), .ovf_q(ovf_ex)
  );

  et_accum #(.IN_W(PROJ_W), .SUM_W(SUM_W), .SIGNED(1'b1)) u_acc_ey (
    .clk(clk), .rst_n(rst_n), .add_en(v1), .last(frame_last),
    .in_val(py), .sum_q(sum_ey), .ovf_q(ovf_ey)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elem_cnt  <= '0;
      sum_valid <= 1'b0;
    end else begin
      sum_valid <= v1 & frame_last;
      if (v1) elem_cnt <= frame_last ? '0 : elem_cnt + 1'b1;
    end
  end

  // R6: the frame-done strobe lasts one cycle
  p_sum_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |=> !sum_valid);
  // R7: a zero frame length closes a frame on every element
  p_len_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && (frame_len == '0)) |=> sum_valid);
endmodule

// File: tb/et_sum_engine_test.sv
module et_sum_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic elem_valid = 1'b0;
  logic [8:0] elem_em = '0, elem_had = '0, thr_em = '0, thr_had = '0;
  logic [3:0] elem_idx = '0, lut_addr = '0;
  logic [7:0] frame_len = 8'd1;
  logic lut_we = 1'b0;
  logic [9:0] lut_cos = '0, lut_sin = '0;
  logic [4:0] jf_data;
  logic jf_valid, jf_first, sum_valid, ovf_et, ovf_ex, ovf_ey;
  logic [15:0] sum_et, sum_ex, sum_ey;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int cosm [16];
  int sinm [16];
  int acc_et, acc_x, acc_y, ecount, cur_len;
  bit o_et, o_x, o_y;

  et_sum_engine uut (
    .clk(clk), .rst_n(rst_n), .elem_valid(elem_valid), .elem_em(elem_em),
    .elem_had(elem_had), .elem_idx(elem_idx), .thr_em(thr_em), .thr_had(thr_had),
    .frame_len(frame_len), .lut_we(lut_we), .lut_addr(lut_addr),
    .lut_cos(lut_cos), .lut_sin(lut_sin), .jf_data(jf_data), .jf_valid(jf_valid),
    .jf_first(jf_first), .sum_valid(sum_valid), .sum_et(sum_et), .sum_ex(sum_ex),
    .sum_ey(sum_ey), .ovf_et(ovf_et), .ovf_ex(ovf_ex), .ovf_ey(ovf_ey)
  );

  always #5 clk = ~clk;

  localparam int NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {9'd100, 9'd50,  4'd0},
    {9'd10,  9'd200, 4'd1},
    {9'd511, 9'd20,  4'd2},
    {9'd11,  9'd21,  4'd3},
    {9'd511, 9'd511, 4'd4},
    {9'd0,   9'd0,   4'd5},
    {9'd300, 9'd400, 4'd6},
    {9'd9,   9'd300, 4'd15}
  };

  task automatic check(input int act, input int exp, input string req);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cut(input int v, input int t);
    return (v > t) ? v : 0;
  endfunction

  function automatic int s16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  task automatic model_add(input int e, input int idx);
    int cx, cy;
    cx = (e * cosm[idx]) >>> 8;
    cy = (e * sinm[idx]) >>> 8;
    acc_et += e;
    if (acc_et > 65535) begin acc_et = 65535; o_et = 1; end
    acc_x += cx;
    if (acc_x > 32767) begin acc_x = 32767; o_x = 1; end
    if (acc_x < -32768) begin acc_x = -32768; o_x = 1; end
    acc_y += cy;
    if (acc_y > 32767) begin acc_y = 32767; o_y = 1; end
    if (acc_y < -32768) begin acc_y = -32768; o_y = 1; end
  endtask

  task automatic new_frame(input int len);
    @(negedge clk);
    frame_len = 8'(len);
    cur_len = (len == 0) ? 1 : len;
    acc_et = 0; acc_x = 0; acc_y = 0; ecount = 0;
    o_et = 0; o_x = 0; o_y = 0;
  endtask

  task automatic write_lut(input int a, input int c, input int s);
    @(negedge clk);
    lut_we = 1'b1; lut_addr = 4'(a); lut_cos = 10'(c); lut_sin = 10'(s);
    cosm[a] = c; sinm[a] = s;
    @(negedge clk);
    lut_we = 1'b0;
  endtask

  // Drives one element; with dup set, holds elem_valid a second cycle with other data (R9).
  task automatic send(input int em, input int had, input int idx, input bit dup, input bit quiet);
    int e;
    bit last;
    e = cut(em, int'(thr_em)) + cut(had, int'(thr_had));
    @(negedge clk);
    elem_valid = 1'b1; elem_em = 9'(em); elem_had = 9'(had); elem_idx = 4'(idx);
    @(negedge clk);
    if (dup) begin elem_em = 9'd400; elem_had = 9'd400; end
    else elem_valid = 1'b0;
    model_add(e, idx);
    ecount++;
    last = (ecount == cur_len);
    @(negedge clk);
    elem_valid = 1'b0;
    if (!quiet || last) begin
      check(int'(jf_valid), 1, "R3 low valid");
      check(int'(jf_first), 1, "R3 low strobe");
      check(int'(jf_data), e % 32, "R3 low half");
    end
    check(int'(sum_valid), int'(last), "R6 sum_valid");
    if (last) begin
      check(int'(sum_et), acc_et, "R6 R2 sum_et");
      check(s16(sum_ex), acc_x, "R4 sum_ex");
      check(s16(sum_ey), acc_y, "R4 sum_ey");
      check(int'(ovf_et), int'(o_et), "R8 ovf_et");
      check(int'(ovf_ex), int'(o_x), "R8 ovf_ex");
      check(int'(ovf_ey), int'(o_y), "R8 ovf_ey");
      acc_et = 0; acc_x = 0; acc_y = 0; ecount = 0;
      o_et = 0; o_x = 0; o_y = 0;
    end
    @(negedge clk);
    if (!quiet || last) begin
      check(int'(jf_valid), 1, "R3 high valid");
      check(int'(jf_first), 0, "R3 high strobe");
      check(int'(jf_data), e / 32, "R3 high half");
      check(int'(sum_valid), 0, "R6 pulse ends");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin cosm[i] = 0; sinm[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(int'(sum_valid), 0, "R1 sum_valid");
    check(int'(jf_valid), 0, "R1 jf_valid");
    check(int'(jf_first), 0, "R1 jf_first");
    check(int'(jf_data), 0, "R1 jf_data");
    check(int'(sum_et) + int'(sum_ex) + int'(sum_ey), 0, "R1 sums");
    check(int'(ovf_et) + int'(ovf_ex) + int'(ovf_ey), 0, "R1 flags");

    // R1 R5: table starts at zero, so projections are zero
    thr_em = 9'd0; thr_had = 9'd0;
    new_frame(1);
    send(200, 100, 7, 1'b0, 1'b0);

    // R5 programme the table
    for (int i = 0; i < 16; i++) write_lut(i, 256 - 40 * i, -200 + 27 * i);

    // Vector table: two frames of four, with cuts (R2 R3 R4 R6)
    thr_em = 9'd10; thr_had = 9'd20;
    new_frame(4);
    for (int k = 0; k < NV; k++)
      send(int'(VEC[k][21:13]), int'(VEC[k][12:4]), int'(VEC[k][3:0]), 1'b0, 1'b0);

    // R2 each cut acts alone
    new_frame(1);
    send(10, 300, 0, 1'b0, 1'b0);
    new_frame(1);
    send(300, 20, 0, 1'b0, 1'b0);
    new_frame(1);
    send(11, 21, 0, 1'b0, 1'b0);

    // R7 zero frame length behaves as one
    new_frame(0);
    send(60, 70, 2, 1'b0, 1'b0);
    send(80, 90, 3, 1'b0, 1'b0);

    // R9 back-to-back element ignored
    new_frame(1);
    send(50, 60, 0, 1'b1, 1'b0);
    @(negedge clk);
    check(int'(jf_valid), 0, "R9 no extra jet-finder word");
    check(int'(sum_valid), 0, "R9 no extra frame");
    check(int'(sum_et), 110, "R9 sum holds first element only");

    // R8 saturation in all three sums, then clear in next frame
    write_lut(15, 256, -256);
    new_frame(70);
    for (int k = 0; k < 70; k++) send(511, 511, 15, 1'b0, 1'b1);
    check(int'(sum_et), 65535, "R8 total clamps");
    check(s16(sum_ex), 32767, "R8 x clamps high");
    check(s16(sum_ey), -32768, "R8 y clamps low");
    new_frame(2);
    send(100, 100, 15, 1'b0, 1'b0);
    send(30, 40, 1, 1'b0, 1'b0);
    check(int'(ovf_et) + int'(ovf_ex) + int'(ovf_ey), 0, "R8 flags clear in new frame");

    // R5 rewrite then use
    write_lut(3, -512, 511);
    new_frame(1);
    send(400, 300, 3, 1'b0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule